// File: doc/BRIEF.md
# Serial Channel Control and Status Register

This block is the byte-wide control and status register of one serial channel. It sits between the bus interface and the transmit and receive engines. Software can write two enable bits, one for the transmitter and one for the receiver. The other six bits are flags that only the hardware updates. The engines send single-cycle event pulses into the block, such as a frame arriving, a framing or parity fault, or the transmitter taking a byte. The bus side sends two strobes: a write of the transmit buffer and a read of the low byte of the receive buffer.

Error flags are sticky. Each one clears only on the bus event that belongs to it. A summary bit shows whether any error flag is raised. A mode input selects asynchronous or clock-synchronous operation. In synchronous mode the framing, parity and summary bits read as 0. All state is registered, so an event sampled at a clock edge shows in `regData` right after that edge.

Top module: `serial_csr`

## Requirements
- R1: After reset, `regData` reads 8'h02. Transmit buffer empty (bit1) is 1 and every other bit is 0.
- R2: A write (`wrEn`) loads bit0 (transmit enable) and bit2 (receive enable) from `wrData[0]` and `wrData[2]`. The write has no effect on bits 1 and 3 to 7.
- R3: Transmit buffer empty (bit1) goes to 0 on `txBufWrite` and to 1 on `txLoad`. When both arrive in the same cycle, `txBufWrite` wins and the bit reads 0.
- R4: Receive complete (bit3) is set by `rxFrameDone` and cleared by `rxLowRead`. When both arrive in the same cycle, the set wins.
- R5: While receive enable is 0, `rxFrameDone` is ignored. It changes none of bits 3 to 7.
- R6: Overrun (bit4) is set when `rxFrameDone` arrives while receive enable and receive complete are both 1.
- R7: Overrun is cleared only by a write with `wrData[2]`=0. A set in the same cycle wins over the clear, and `rxLowRead` does not clear it.
- R8: Framing error (bit5) and parity error (bit6) are set by `rxFrameDone` together with `rxFrameErr` or `rxParityErr`. They are cleared by a write with `wrData[2]`=0 or by `rxLowRead`. A set in the same cycle wins over the clear.
- R9: In asynchronous mode (`syncMode`=0), error summary (bit7) equals the OR of bits 4, 5 and 6 in the same cycle.
- R10: With `syncMode`=1, bits 5, 6 and 7 read as 0. Bit4 still reads the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Bus write strobe for this register |
| wrData | input | 8 | Bus write data |
| syncMode | input | 1 | 1 selects clock-synchronous mode, 0 selects asynchronous mode |
| txBufWrite | input | 1 | Bus write of the transmit buffer |
| txLoad | input | 1 | Transmitter moved the buffered byte into its shifter |
| rxFrameDone | input | 1 | Receiver finished a frame |
| rxFrameErr | input | 1 | Framing fault on the finished frame |
| rxParityErr | input | 1 | Parity fault on the finished frame |
| rxLowRead | input | 1 | Bus read of the receive buffer low byte |
| regData | output | 8 | Current register value |

## Verification
The hardest situations to reach are the ones where a set and a clear hit the same flag in the same cycle. One case is a frame with errors arriving in the cycle the receive buffer is read. Another is a frame arriving in the cycle software drops receive enable. A third is a transmit buffer write arriving together with a transmitter load. Directed sequences build each of these on purpose, after first raising receive complete so that overrun can fire. A long seeded random phase then drives all event inputs together at moderate rates, with occasional mode flips. Every cycle is compared against a reference model in the bench.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;
  localparam int REG_W = 8;
  localparam int TX_EN_BIT = 0;
  localparam int TX_EMPTY_BIT = 1;
  localparam int RX_EN_BIT = 2;
  localparam int RX_DONE_BIT = 3;
  localparam int OVR_BIT = 4;
  localparam int FRM_BIT = 5;
  localparam int PAR_BIT = 6;
  localparam int SUM_BIT = 7;
  localparam logic [REG_W-1:0] RESET_VAL = REG_W'(1) << TX_EMPTY_BIT;

  typedef struct packed {
    logic loadEnables;
    logic setTxEmpty;
    logic clrTxEmpty;
    logic setRxDone;
    logic clrRxDone;
    logic setOvr;
    logic clrOvr;
    logic setFrm;
    logic setPar;
    logic clrLineErr;
  } csrStrobes_t;
endpackage

// File: rtl/serial_csr_ctrl.sv
module serial_csr_ctrl
  import serial_csr_pkg::*;
(
  input  logic        wrEn,
  input  logic        wrRxEnBit,
  input  logic        rxEnNow,
  input  logic        rxDoneNow,
  input  logic        txBufWrite,
  input  logic        txLoad,
  input  logic        rxFrameDone,
  input  logic        rxFrameErr,
  input  logic        rxParityErr,
  input  logic        rxLowRead,
  output csrStrobes_t strb
);
  logic rxDisableWr;
  logic frameTaken;

  always_comb begin
    rxDisableWr = wrEn && !wrRxEnBit;
    frameTaken  = rxFrameDone && rxEnNow;

    strb.loadEnables = wrEn;
    // buffer write beats a simultaneous load: fresh data is present
    strb.clrTxEmpty  = txBufWrite;
    strb.setTxEmpty  = txLoad && !txBufWrite;
    strb.setRxDone   = frameTaken;
    strb.clrRxDone   = rxLowRead;
    strb.setOvr      = frameTaken && rxDoneNow;
    strb.clrOvr      = rxDisableWr;
    strb.setFrm      = frameTaken && rxFrameErr;
    strb.setPar      = frameTaken && rxParityErr;
    strb.clrLineErr  = rxDisableWr || rxLowRead;
  end
endmodule

// File: rtl/serial_csr_datapath.sv
module serial_csr_datapath
  import serial_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  csrStrobes_t      strb,
  input  logic             wrTxEnBit,
  input  logic             wrRxEnBit,
  input  logic             syncMode,
  output logic             rxEnQ,
  output logic             rxDoneQ,
  output logic [REG_W-1:0] regData
);
  logic txEnQ;
  logic txEmptyQ;
  logic ovrQ;
  logic frmQ;
  logic parQ;

  // set has priority over clear so no event is dropped
  function automatic logic nextFlag(input logic q, input logic setP, input logic clrP);
    return setP | (q & ~clrP);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEnQ    <= RESET_VAL[TX_EN_BIT];
      txEmptyQ <= RESET_VAL[TX_EMPTY_BIT];
      rxEnQ    <= RESET_VAL[RX_EN_BIT];
      rxDoneQ  <= RESET_VAL[RX_DONE_BIT];
      ovrQ     <= RESET_VAL[OVR_BIT];
      frmQ     <= RESET_VAL[FRM_BIT];
      parQ     <= RESET_VAL[PAR_BIT];
    end else begin
      if (strb.loadEnables) begin
        txEnQ <= wrTxEnBit;
        rxEnQ <= wrRxEnBit;
      end
      txEmptyQ <= nextFlag(txEmptyQ, strb.setTxEmpty, strb.clrTxEmpty);
      rxDoneQ  <= nextFlag(rxDoneQ, strb.setRxDone, strb.clrRxDone);
      ovrQ     <= nextFlag(ovrQ, strb.setOvr, strb.clrOvr);
      frmQ     <= nextFlag(frmQ, strb.setFrm, strb.clrLineErr);
      parQ     <= nextFlag(parQ, strb.setPar, strb.clrLineErr);
    end
  end

  logic frmVis;
  logic parVis;

  always_comb begin
    frmVis = frmQ && !syncMode;
    parVis = parQ && !syncMode;
    regData = '0;
    regData[TX_EN_BIT]    = txEnQ;
    regData[TX_EMPTY_BIT] = txEmptyQ;
    regData[RX_EN_BIT]    = rxEnQ;
    regData[RX_DONE_BIT]  = rxDoneQ;
    regData[OVR_BIT]      = ovrQ;
    regData[FRM_BIT]      = frmVis;
    regData[PAR_BIT]      = parVis;
    regData[SUM_BIT]      = !syncMode && (ovrQ || frmQ || parQ);
  end
endmodule

// File: rtl/serial_csr.sv
module serial_csr
  import serial_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             syncMode,
  input  logic             txBufWrite,
  input  logic             txLoad,
  input  logic             rxFrameDone,
  input  logic             rxFrameErr,
  input  logic             rxParityErr,
  input  logic             rxLowRead,
  output logic [REG_W-1:0] regData
);
  csrStrobes_t strb;
  logic rxEnQ;
  logic rxDoneQ;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData;

  serial_csr_ctrl u_ctrl (
    .wrEn        (wrEn),
    .wrRxEnBit   (wrData[RX_EN_BIT]),
    .rxEnNow     (rxEnQ),
    .rxDoneNow   (rxDoneQ),
    .txBufWrite  (txBufWrite),
    .txLoad      (txLoad),
    .rxFrameDone (rxFrameDone),
    .rxFrameErr  (rxFrameErr),
    .rxParityErr (rxParityErr),
    .rxLowRead   (rxLowRead),
    .strb        (strb)
  );

  serial_csr_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrTxEnBit (wrData[TX_EN_BIT]),
    .wrRxEnBit (wrData[RX_EN_BIT]),
    .syncMode  (syncMode),
    .rxEnQ     (rxEnQ),
    .rxDoneQ   (rxDoneQ),
    .regData   (regData)
  );
endmodule

// File: rtl/serial_csr_chk.sv
module serial_csr_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       syncMode,
  input logic       txBufWrite,
  input logic       rxFrameDone,
  input logic       rxLowRead,
  input logic [7:0] regData
);
  // R3
  tx_write_clears_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    txBufWrite |=> !regData[1]);

  // R5
  rx_disabled_ignores_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxFrameDone && !regData[2] && !rxLowRead) |=> $stable(regData[3]));

  // R6
  overrun_on_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxFrameDone && regData[2] && regData[3]) |=> regData[4]);

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regData[4] && !(wrEn && !wrData[2])) |=> regData[4]);

  // R9
  sum_tracks_errors_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncMode |-> (regData[7] == (regData[4] | regData[5] | regData[6])));

  // R10
  sync_masks_line_errors_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncMode |-> (regData[7:5] == 3'b000));
endmodule

bind serial_csr serial_csr_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .syncMode    (syncMode),
  .txBufWrite  (txBufWrite),
  .rxFrameDone (rxFrameDone),
  .rxLowRead   (rxLowRead),
  .regData     (regData)
);

// File: tb/serial_csr_bench.sv
module serial_csr_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       syncMode = 1'b0;
  logic       txBufWrite = 1'b0;
  logic       txLoad = 1'b0;
  logic       rxFrameDone = 1'b0;
  logic       rxFrameErr = 1'b0;
  logic       rxParityErr = 1'b0;
  logic       rxLowRead = 1'b0;
  logic [7:0] regData;

  int checks = 0;
  int errors = 0;

  logic mTxEn, mEmpty, mRxEn, mDone, mOvr, mFrm, mPar;

  always #2 clk = ~clk;

  serial_csr u_serial_csr (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .syncMode(syncMode),
    .txBufWrite(txBufWrite), .txLoad(txLoad), .rxFrameDone(rxFrameDone),
    .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr), .rxLowRead(rxLowRead),
    .regData(regData)
  );

  function automatic logic [7:0] expRead(input logic sm);
    logic [7:0] v;
    v = {1'b0, mPar & ~sm, mFrm & ~sm, mOvr, mDone, mRxEn, mEmpty, mTxEn};
    v[7] = ~sm & (mOvr | mFrm | mPar);
    return v;
  endfunction

  function automatic string tagOf(input int b, input logic sm);
    if (sm && b >= 5) return "R10";
    case (b)
      0, 2: return "R2";
      1: return "R3";
      3: return "R4";
      4: return "R6";
      5, 6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: regData=%02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic resetModel();
    mTxEn = 0; mEmpty = 1; mRxEn = 0; mDone = 0; mOvr = 0; mFrm = 0; mPar = 0;
  endtask

  // one clock with the given inputs, then a whole-register compare
  task automatic step(input logic we, input logic [7:0] wd, input logic sm, input logic tbw,
                      input logic tld, input logic fd, input logic fe, input logic pe,
                      input logic lr);
    logic rxDis, fok;
    logic [7:0] exp;
    wrEn = we; wrData = wd; syncMode = sm; txBufWrite = tbw; txLoad = tld;
    rxFrameDone = fd; rxFrameErr = fe; rxParityErr = pe; rxLowRead = lr;
    @(posedge clk);
    rxDis = we && !wd[2];
    fok = fd && mRxEn;
    mOvr = (fok && mDone) || (mOvr && !rxDis);
    mFrm = (fok && fe) || (mFrm && !(rxDis || lr));
    mPar = (fok && pe) || (mPar && !(rxDis || lr));
    mDone = fok || (mDone && !lr);
    mEmpty = tbw ? 1'b0 : (tld ? 1'b1 : mEmpty);
    if (we) begin mTxEn = wd[0]; mRxEn = wd[2]; end
    @(negedge clk);
    exp = expRead(sm);
    checks++;
    if (regData !== exp) begin
      int bad;
      bad = 0;
      for (int i = 7; i >= 0; i--) if (regData[i] !== exp[i]) bad = i;
      errors++;
      $display("FAIL %s: regData=%02h expected %02h", tagOf(bad, sm), regData, exp);
    end
    wrEn = 0; txBufWrite = 0; txLoad = 0; rxFrameDone = 0;
    rxFrameErr = 0; rxParityErr = 0; rxLowRead = 0;
  endtask

  task automatic idle(input logic sm);
    step(0, 8'h00, sm, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    resetModel();
    repeat (3) @(negedge clk);
    chk("R1", regData, 8'h02);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", regData, 8'h02);

    // R2: only enable bits are writable
    step(1, 8'hFF, 0, 0, 0, 0, 0, 0, 0);
    chk("R2", regData, 8'h07);
    step(1, 8'hFA, 0, 0, 0, 0, 0, 0, 0);
    chk("R2", regData, 8'h02);

    // R3: empty flag handling, write wins over load
    step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R3", regData, 8'h00);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R3", regData, 8'h02);
    step(0, 0, 0, 1, 1, 0, 0, 0, 0);
    chk("R3", regData, 8'h00);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);

    // R5: frames ignored while receiver disabled
    step(0, 0, 0, 0, 0, 1, 1, 1, 0);
    chk("R5", regData, 8'h02);

    // R4, R6: enable, take frame, then overrun
    step(1, 8'h04, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R4", regData, 8'h0E);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R6", regData, 8'h9E);
    // R7: low read clears receive complete but not overrun
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R7", regData, 8'h96);
    // R4: set beats clear on receive complete
    step(0, 0, 0, 0, 0, 1, 0, 0, 1);
    chk("R4", regData, 8'h9E);
    // R8, R9: errors on a frame while complete already set
    step(0, 0, 0, 0, 0, 1, 1, 1, 0);
    chk("R8", regData, 8'hFE);
    // R10: synchronous mode masks bits 5..7
    idle(1);
    chk("R10", regData, 8'h1E);
    // R8: low read clears line errors; a fresh framing fault in the same cycle wins
    step(0, 0, 0, 0, 0, 1, 1, 0, 1);
    chk("R8", regData, 8'hBE);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8", regData, 8'h96);
    // R7: disabling write with a concurrent frame; set wins for overrun
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    step(1, 8'h00, 0, 0, 0, 1, 0, 1, 0);
    chk("R7", regData, 8'hDA);
    step(1, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    chk("R7", regData, 8'h0A);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R4", regData, 8'h02);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      logic sm;
      sm = ($urandom_range(0, 15) == 0) ? ~syncMode : syncMode;
      step(($urandom_range(0, 9) == 0), 8'($urandom()) | (($urandom_range(0, 3) != 0) ? 8'h04 : 8'h00),
           sm, ($urandom_range(0, 5) == 0), ($urandom_range(0, 4) == 0),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule